// File: doc/BRIEF.md
# Watchdog and Interval Timer with Keyed Feed

This block guards a processor against software that has stopped running. A down counter is loaded from a reload register and counts down through a prescaler chain. The chain is a fixed divide-by-32 stage followed by a 12-bit programmable prescaler. The counter's tick comes from one of three clock enables: the peripheral clock, a slow watchdog oscillator, or a low-speed crystal. Software must restart the counter before it passes zero. To do so it writes two key bytes, one to each of two feed addresses, with no other write between them. If the counter underflows, or the key is written wrongly, a one-cycle reset request goes out.

Configuration is written to a control register. A control write only fills a shadow copy. The running timer takes the new settings at the next valid feed, and that feed must be the very next bus activity. When the watchdog strap input is low, the same counter works as an interval timer. In that mode an underflow sets a sticky flag and raises an interrupt instead of a reset. While power-down is asserted, counting stops if the peripheral clock is the selected source. A watchdog reset leaves the configuration and reload value unchanged. Only the block's own reset input, which stands for power-on reset, clears them.

Top module: `wdog_feed_timer`

## Requirements
- R1: After reset, the control read (address 0) returns 0xE0 and both the reload read (address 1) and the count read (address 2) return 0xFF. The reset request and the interrupt are low.
- R2: A valid feed loads the down counter from the reload register. A valid feed is a write of 0xA5 to address 2 and then, as the next write, a write of 0x5A to address 3.
- R3: With prescaler select value s, the counter decrements once every 32 enabled source cycles when s is 0, and once every 32·2^(s+5) enabled cycles otherwise. From reload value N, an underflow follows N+1 decrements.
- R4: In watchdog mode (wd_mode_en high), an underflow gives a reset request exactly one cycle wide and sets the timeout flag (control bit 1). The interrupt stays low.
- R5: In watchdog mode, each of the following gives a reset request in the cycle after the offending write: a wrong first key, a wrong second key, a second-key write with no first key before it, and any write other than the second key directly after the first key.
- R6: A control write (bits 7:5 prescaler select; bits 4:3 source, where 0 is the peripheral clock, 1 the watchdog oscillator, and 2 or 3 the crystal; bit 0 run) does not change the control read back. Its fields take effect at the next valid feed.
- R7: In watchdog mode, if the write directly after a control write is not the first feed key, a reset request follows. This includes a second control write.
- R8: In timer mode (wd_mode_en low), an underflow reloads the counter, sets the timeout flag and raises wdt_irq, and never gives a reset request. Invalid feeds are ignored, and the counter holds while the run bit is 0.
- R9: The timeout flag stays set until a control write with bit 1 at 0. Writing 1 to that bit has no effect.
- R10: With the peripheral-clock source and pwr_down high, the counter holds. With the watchdog-oscillator source it keeps counting during power-down.
- R11: A watchdog reset preserves the active configuration and the reload value.
- R12: Only the enable of the selected source advances the counter. With the crystal selected and its enable low, an active peripheral-clock enable has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload, 2 first key, 3 second key |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 reload, 2 count, 3 zero |
| rd_data | output | 8 | Combinational read data |
| en_pclk | input | 1 | Peripheral-clock enable |
| en_wdosc | input | 1 | Watchdog-oscillator enable |
| en_xtal | input | 1 | Low-speed crystal enable |
| pwr_down | input | 1 | CPU power-down indication |
| wd_mode_en | input | 1 | High selects watchdog mode, low selects interval timer |
| wdt_rst_req | output | 1 | One-cycle reset request |
| wdt_irq | output | 1 | Interval-timer interrupt |

## Verification
The hardest case to reach is the underflow itself. With the default configuration the count spans millions of cycles, so the bench first writes a small reload value and a fast tap, feeds, and then reads the count at mid-tick points to pin the decrement timing before it waits for the underflow window. Keyed-feed errors and an unfollowed control write are walked as a vector table while a slow configuration keeps underflows away. Each entry is followed by a count of reset pulses.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_RELOAD = 2'd1;
    localparam logic [1:0] A_KEY1   = 2'd2;
    localparam logic [1:0] A_KEY2   = 2'd3;

    localparam logic [7:0] KEY1_VAL = 8'hA5;
    localparam logic [7:0] KEY2_VAL = 8'h5A;

    typedef enum logic [1:0] {
        SRC_PCLK  = 2'd0,
        SRC_WDOSC = 2'd1,
        SRC_XTAL  = 2'd2,
        SRC_XTAL2 = 2'd3
    } src_e;

    typedef struct packed {
        logic [2:0] presc;
        src_e       src;
        logic       run;
    } cfg_t;

    typedef enum logic {
        FD_IDLE  = 1'b0,
        FD_ARMED = 1'b1
    } feed_st_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
    import wdog_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pclk,
    input  logic en_wdosc,
    input  logic en_xtal,
    input  src_e src,
    input  logic pwr_down,
    input  logic run,
    input  logic clr,
    output logic base_tick
);
    logic [DIV_W-1:0] div_d, div_q;
    logic             src_en;
    logic             step;

    always_comb begin
        unique case (src)
            SRC_PCLK:  src_en = en_pclk & ~pwr_down;
            SRC_WDOSC: src_en = en_wdosc;
            default:   src_en = en_xtal;
        endcase
        step      = src_en & run;
        base_tick = step && (div_q == {DIV_W{1'b1}});
        if (clr)       div_d = '0;
        else if (step) div_d = div_q + 1'b1;
        else           div_d = div_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_W = 12,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             dec
);
    localparam int SEL_N  = 1 << SEL_W;
    localparam int W_OFFS = PRE_W - (SEL_N - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] tap_mask [SEL_N];

    for (genvar g = 0; g < SEL_N; g++) begin : g_tap
        if (g == 0) begin : g_direct
            assign tap_mask[g] = '0;
        end else begin : g_div
            assign tap_mask[g] = {PRE_W{1'b1}} >> (PRE_W - (g + W_OFFS));
        end
    end

    always_comb begin
        dec = base_tick && ((pre_q & tap_mask[sel]) == tap_mask[sel]);
        if (clr)            pre_d = '0;
        else if (base_tick) pre_d = pre_q + 1'b1;
        else                pre_d = pre_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdog_feed_dec.sv
module wdog_feed_dec
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       clr,
    output logic       feed_ok,
    output logic       feed_bad
);
    feed_st_e st_d, st_q;
    logic     pend_d, pend_q;

    always_comb begin
        st_d     = st_q;
        pend_d   = pend_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                A_KEY1: begin
                    if (st_q == FD_IDLE && wr_data == KEY1_VAL) st_d = FD_ARMED;
                    else                                        feed_bad = 1'b1;
                end
                A_KEY2: begin
                    if (st_q == FD_ARMED && wr_data == KEY2_VAL) feed_ok  = 1'b1;
                    else                                         feed_bad = 1'b1;
                end
                default: begin
                    if (st_q == FD_ARMED || pend_q) feed_bad = 1'b1;
                    else if (wr_addr == A_CTRL)     pend_d   = 1'b1;
                end
            endcase
        end
        if (feed_ok || feed_bad || clr) begin
            st_d   = FD_IDLE;
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FD_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/wdog_feed_timer.sv
module wdog_feed_timer
    import wdog_pkg::*;
#(
    parameter int         CNT_W      = 8,
    parameter int         PRE_W      = 12,
    parameter int         DIV_W      = 5,
    parameter logic [2:0] RST_PRESC  = 3'd7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       en_pclk,
    input  logic       en_wdosc,
    input  logic       en_xtal,
    input  logic       pwr_down,
    input  logic       wd_mode_en,
    output logic       wdt_rst_req,
    output logic       wdt_irq
);
    localparam logic [CNT_W-1:0] RST_RELOAD = {CNT_W{1'b1}};
    localparam cfg_t RST_CFG = '{presc: RST_PRESC, src: SRC_PCLK, run: 1'b0};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        cfg_t             act;
        cfg_t             shd;
        logic             tof;
        logic             rst_req;
    } state_t;

    localparam state_t RST_STATE = '{
        cnt: RST_RELOAD, reload: RST_RELOAD, act: RST_CFG,
        shd: RST_CFG, tof: 1'b0, rst_req: 1'b0
    };

    state_t state_d, state_q;
    logic   base_tick, dec, feed_ok, feed_bad;
    logic   counting, underflow, wd_rst, chain_clr;

    assign counting  = wd_mode_en | state_q.act.run;
    assign underflow = dec && (state_q.cnt == '0);
    assign wd_rst    = wd_mode_en & (feed_bad | (underflow & ~feed_ok));
    assign chain_clr = feed_ok | wd_rst;

    wdog_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .en_pclk(en_pclk), .en_wdosc(en_wdosc), .en_xtal(en_xtal),
        .src(state_q.act.src), .pwr_down(pwr_down), .run(counting),
        .clr(chain_clr), .base_tick(base_tick)
    );

    wdog_prescaler #(.PRE_W(PRE_W), .SEL_W(3)) u_presc (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .clr(chain_clr), .sel(state_q.act.presc), .dec(dec)
    );

    wdog_feed_dec u_feed (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clr(wd_rst),
        .feed_ok(feed_ok), .feed_bad(feed_bad)
    );

    always_comb begin
        state_d         = state_q;
        state_d.rst_req = 1'b0;
        if (wr_en && wr_addr == A_CTRL) begin
            state_d.shd.presc = wr_data[7:5];
            state_d.shd.src   = src_e'(wr_data[4:3]);
            state_d.shd.run   = wr_data[0];
            if (!wr_data[1]) state_d.tof = 1'b0;
        end
        if (wr_en && wr_addr == A_RELOAD) state_d.reload = wr_data[CNT_W-1:0];
        if (dec) begin
            if (state_q.cnt == '0) state_d.cnt = state_q.reload;
            else                   state_d.cnt = state_q.cnt - 1'b1;
        end
        if (underflow) state_d.tof = 1'b1;
        if (feed_ok) begin
            state_d.cnt = state_q.reload;
            state_d.act = state_q.shd;
        end
        if (wd_rst) begin
            state_d.cnt     = state_q.reload;
            state_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL:   rd_data = {state_q.act.presc, state_q.act.src, 1'b0,
                                 state_q.tof, state_q.act.run};
            A_RELOAD: rd_data = 8'(state_q.reload);
            A_KEY1:   rd_data = 8'(state_q.cnt);
            default:  rd_data = 8'h00;
        endcase
    end

    assign wdt_rst_req = state_q.rst_req;
    assign wdt_irq     = state_q.tof & ~wd_mode_en;
endmodule

// File: rtl/wdog_feed_timer_chk.sv
module wdog_feed_timer_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             pwr_down,
    input logic             wd_mode_en,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             tof,
    input cfg_t             act,
    input logic             feed_ok,
    input logic             wd_rst
);
    AST_FEED_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |=> cnt == $past(reload)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) - 1'b1)) || (cnt == $past(reload))); // R3

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !wr_en) |=> !rst_req); // R4

    AST_CFG_VIA_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (act != $past(act)) |-> $past(feed_ok)); // R6

    AST_TIMER_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_mode_en |=> !rst_req); // R8

    AST_TOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tof) |-> ($past(wr_en) && $past(wr_addr) == A_CTRL && !$past(wr_data[1]))); // R9

    AST_PWRDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && act.src == SRC_PCLK && !feed_ok && !wd_rst) |=> cnt == $past(cnt)); // R10
endmodule

bind wdog_feed_timer wdog_feed_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwr_down(pwr_down), .wd_mode_en(wd_mode_en),
    .rst_req(wdt_rst_req), .cnt(state_q.cnt), .reload(state_q.reload),
    .tof(state_q.tof), .act(state_q.act), .feed_ok(feed_ok), .wd_rst(wd_rst)
);

// File: tb/test_wdog_feed_timer.sv
module test_wdog_feed_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       en_pclk = 1'b1;
    logic       en_wdosc = 1'b0;
    logic       en_xtal = 1'b0;
    logic       pwr_down = 1'b0;
    logic       wd_mode_en = 1'b1;
    logic       wdt_rst_req, wdt_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int rst_seen = 0;
    bit done = 1'b0;
    int osc_ph = 0;

    always #5 clk = ~clk;

    wdog_feed_timer i_wdog_feed_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .en_pclk(en_pclk), .en_wdosc(en_wdosc), .en_xtal(en_xtal),
        .pwr_down(pwr_down), .wd_mode_en(wd_mode_en),
        .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
    );

    always @(negedge clk) begin
        osc_ph   <= (osc_ph + 1) % 4;
        en_wdosc <= (osc_ph == 3);
        if (wdt_rst_req) rst_seen <= rst_seen + 1;
    end

    typedef struct packed {
        logic [1:0] a;
        logic [7:0] d;
        logic       exp_rst;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{2'd2, 8'hA5, 1'b0}, '{2'd3, 8'h5A, 1'b0},
        '{2'd3, 8'h5A, 1'b1},
        '{2'd2, 8'hA4, 1'b1},
        '{2'd2, 8'hA5, 1'b0}, '{2'd3, 8'h5B, 1'b1},
        '{2'd2, 8'hA5, 1'b0}, '{2'd1, 8'hFF, 1'b1},
        '{2'd2, 8'hA5, 1'b0}, '{2'd2, 8'hA5, 1'b1},
        '{2'd0, 8'hE0, 1'b0}, '{2'd1, 8'hFF, 1'b1},
        '{2'd0, 8'hE0, 1'b0}, '{2'd2, 8'hA5, 1'b0}, '{2'd3, 8'h5A, 1'b0},
        '{2'd0, 8'hE0, 1'b0}, '{2'd0, 8'hE0, 1'b1},
        '{2'd2, 8'hA5, 1'b0}, '{2'd3, 8'h5A, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic feed();
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h5A);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v, base;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'hE0);
        rd(2'd1, v); chk("R1 reload", v, 8'hFF);
        rd(2'd2, v); chk("R1 count", v, 8'hFF);
        chk("R1 rst_req", int'(wdt_rst_req), 0);
        chk("R1 irq", int'(wdt_irq), 0);

        // R5 R7 feed-sequence vectors in watchdog mode
        for (int i = 0; i < NVEC; i++) begin
            base = rst_seen;
            wr(VEC[i].a, VEC[i].d);
            wait_n(1);
            chk($sformatf("R5 R7 vector %0d reset", i), rst_seen - base, int'(VEC[i].exp_rst));
        end

        // R6 shadowed control
        wr(2'd0, 8'h08);
        rd(2'd0, v); chk("R6 ctrl before feed", v, 8'hE0);
        feed();
        rd(2'd0, v); chk("R6 ctrl after feed", v, 8'h08);

        // R2 R3 R4 underflow timing, sel 0, reload 2
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h00);
        base = rst_seen;
        feed();
        rd(2'd2, v); chk("R2 count after feed", v, 2);
        wait_n(16); rd(2'd2, v); chk("R3 count at 16", v, 2);
        wait_n(32); rd(2'd2, v); chk("R3 count at 48", v, 1);
        wait_n(32); rd(2'd2, v); chk("R3 count at 80", v, 0);
        wait_n(14); chk("R4 no reset before underflow", rst_seen - base, 0);
        wait_n(4);  chk("R4 single reset pulse", rst_seen - base, 1);
        rd(2'd0, v); chk("R4 timeout flag", (v >> 1) & 1, 1);
        chk("R4 irq low in watchdog mode", int'(wdt_irq), 0);
        // R11 configuration survives watchdog reset
        rd(2'd1, v); chk("R11 reload kept", v, 2);
        rd(2'd0, v); chk("R11 ctrl kept", v & 8'hFD, 8'h00);
        wr(2'd0, 8'hE0); feed();

        // R3 prescaler select 1, reload 0
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h20);
        base = rst_seen;
        feed();
        wait_n(2040); chk("R3 sel1 no early underflow", rst_seen - base, 0);
        wait_n(16);   chk("R3 sel1 underflow", rst_seen - base, 1);
        wr(2'd1, 8'hFF); wr(2'd0, 8'hE0); feed();

        // R10 power-down with peripheral clock
        wr(2'd1, 8'h04);
        wr(2'd0, 8'h00);
        base = rst_seen;
        feed();
        pwr_down = 1'b1;
        wait_n(300); rd(2'd2, v); chk("R10 pclk held in power-down", v, 4);
        pwr_down = 1'b0;
        wait_n(40); rd(2'd2, v); chk("R10 pclk resumes", v, 3);
        // R10 watchdog oscillator keeps running
        wr(2'd0, 8'h08); feed();
        pwr_down = 1'b1;
        wait_n(300); rd(2'd2, v); chk("R10 wdosc counts in power-down", int'(v < 4), 1);
        chk("R10 no reset", rst_seen - base, 0);
        pwr_down = 1'b0;
        wr(2'd0, 8'hE0); feed();

        // R12 crystal selected with its enable low
        wr(2'd0, 8'h10); feed();
        wait_n(200); rd(2'd2, v); chk("R12 pclk ignored when crystal selected", v, 4);
        wr(2'd0, 8'hE0); feed();

        // R8 R9 interval timer
        wd_mode_en = 1'b0;
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h01);
        base = rst_seen;
        feed();
        wait_n(60); chk("R8 irq low before underflow", int'(wdt_irq), 0);
        wait_n(10); chk("R8 irq after underflow", int'(wdt_irq), 1);
        rd(2'd2, v); chk("R8 counter reloaded", v, 1);
        wait_n(10); chk("R9 flag holds", int'(wdt_irq), 1);
        wr(2'd0, 8'h03);
        wait_n(1); chk("R9 writing one keeps flag", int'(wdt_irq), 1);
        wr(2'd3, 8'h5A);
        wait_n(1); chk("R8 invalid feed ignored", rst_seen - base, 0);
        wr(2'd0, 8'h01);
        chk("R9 flag cleared by zero write", int'(wdt_irq), 0);
        chk("R8 no reset in timer mode", rst_seen - base, 0);
        wr(2'd0, 8'h00); feed();
        rd(2'd2, base);
        wait_n(100); rd(2'd2, v); chk("R8 run off holds count", v, base);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule